// File: doc/BRIEF.md
# Platform System I/O Register Block

This block is a byte-wide register file that sits on an ISA-style I/O port bus. It decodes a fixed set of 12-bit port addresses and holds a few pieces of board-level control state. These are a soft-reset latch, a system control byte, and an I/O map type selector. It also returns the values of two 8-bit strap inputs, one describing installed equipment and one identifying the board. Three control lines leave the block: a soft-reset request, a non-contiguous I/O map select, and a sticky halt flag. The halt flag is raised when software asks for a byte order the platform does not support.

All registers use reversed bit numbering. Logical bit n of a register is physical data bit (7 - n), so logical bit 7 is the least significant bit. Some ports accept only writes and discard them; on a read they return 0xFF. Other ports are read-only, and writes to them are dropped. A separate 4-byte memory-mapped status window answers 32-bit reads with zero. It flags any other access that falls inside the window.

Top module: `sysio_regs`

## Requirements
- R1: While `rst_n` is low and after its release, `soft_rst_o` and `le_halt_o` are 0 and `map_noncontig_o` is 1. A read of port 0x092 returns 0x00, port 0x81C returns 0x00 and port 0x850 returns 0x01.
- R2: A write to port 0x092 stores only data bit 0 (value 0x01, soft reset). `soft_rst_o` follows the stored bit, and a read of 0x092 returns exactly the stored bit.
- R3: A write to port 0x092 with data bit 1 (value 0x02, little-endian request) set drives `le_halt_o` to 1. The flag then stays at 1 until reset, and bit 1 is never stored or read back.
- R4: A write to port 0x81C stores `wdata & 0xF0`, which are logical bits 0 to 3. A read of 0x81C returns that masked value.
- R5: A write to port 0x850 stores `wdata & 0x01`, and `map_noncontig_o` equals the stored bit. `map_noncontig_o` changes only through a write to 0x850 or through reset.
- R6: A read of port 0x80C returns `strap_equip`, a read of 0x852 returns `strap_board`, and a read of 0x818 returns 0x00.
- R7: A read of the write-only ports 0x808, 0x810, 0x812 and 0x814 returns 0xFF, and so does a read of any address that is not decoded. A write to any address other than 0x092, 0x81C and 0x850 changes no stored state and no output.
- R8: Read data is registered. `io_rdata` takes its new value on the clock edge that samples `io_rd` and holds it while `io_rd` is low. Control outputs change on the edge that captures the write.
- R9: In the memory window at 0xBFFFEFF0 to 0xBFFFEFF3, a read with `mem_word` = 1 gives `mem_ack` = 1 one cycle later. Any other read or write inside the window gives `mem_err` = 1 one cycle later. `mem_rdata` is always zero, and an access outside the window raises neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| io_addr | input | 12 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Registered I/O read data |
| strap_equip | input | 8 | Equipment strap value |
| strap_board | input | 8 | Board identification strap value |
| mem_addr | input | 32 | Memory access address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_word | input | 1 | Access is a full 32-bit word |
| mem_rdata | output | 32 | Status window read data, always zero |
| mem_ack | output | 1 | Valid 32-bit window read, one cycle after the strobe |
| mem_err | output | 1 | Rejected window access, one cycle after the strobe |
| soft_rst_o | output | 1 | Soft-reset request |
| map_noncontig_o | output | 1 | Non-contiguous I/O map select |
| le_halt_o | output | 1 | Sticky unsupported byte-order halt flag |

## Verification
The checker watches a set of cycle-level rules on every cycle. It confirms that writes to the soft-reset and map-type ports drive their outputs on the next edge, and that the halt flag never falls outside reset. It also confirms that strap and keylock reads, reads of write-only ports, and reads of the window return what they should, and that read data holds between strobes. What a property cannot show is handled by the bench's scenarios. These cover the masking across every data value, the complete address map over all 4096 port addresses, and the guarantee that a write anywhere else leaves all stored state untouched. Reset restoring the non-zero map type is also checked there.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  localparam int DW     = 8;
  localparam int AW     = 12;
  localparam int NPORT  = 10;
  localparam int MEM_AW = 32;
  localparam int MEM_DW = 32;

  typedef enum logic [3:0] {
    PI_SRST  = 4'd0,
    PI_LAMP  = 4'd1,
    PI_EQUIP = 4'd2,
    PI_PWA   = 4'd3,
    PI_PWB   = 4'd4,
    PI_L2INV = 4'd5,
    PI_KEY   = 4'd6,
    PI_CTRL  = 4'd7,
    PI_MAP   = 4'd8,
    PI_BOARD = 4'd9
  } port_idx_e;

  localparam logic [AW-1:0] ADDR_SRST  = 12'h092;
  localparam logic [AW-1:0] ADDR_LAMP  = 12'h808;
  localparam logic [AW-1:0] ADDR_EQUIP = 12'h80C;
  localparam logic [AW-1:0] ADDR_PWA   = 12'h810;
  localparam logic [AW-1:0] ADDR_PWB   = 12'h812;
  localparam logic [AW-1:0] ADDR_L2INV = 12'h814;
  localparam logic [AW-1:0] ADDR_KEY   = 12'h818;
  localparam logic [AW-1:0] ADDR_CTRL  = 12'h81C;
  localparam logic [AW-1:0] ADDR_MAP   = 12'h850;
  localparam logic [AW-1:0] ADDR_BOARD = 12'h852;

  localparam logic [NPORT*AW-1:0] PORT_TABLE = {
    ADDR_BOARD, ADDR_MAP, ADDR_CTRL, ADDR_KEY, ADDR_L2INV,
    ADDR_PWB, ADDR_PWA, ADDR_EQUIP, ADDR_LAMP, ADDR_SRST
  };

  // Access capability per port index (bit i belongs to index i)
  localparam logic [NPORT-1:0] CAN_READ  = 10'b11_1100_0101;
  localparam logic [NPORT-1:0] CAN_WRITE = 10'b01_1011_1011;

  localparam logic [MEM_AW-1:0] WIN_BASE  = 32'hBFFF_EFF0;
  localparam int unsigned       WIN_BYTES = 4;

  // Reversed numbering: logical bit n sits at physical bit DW-1-n
  function automatic logic [DW-1:0] lbit(input int n);
    logic [DW-1:0] v;
    v = '0;
    v[DW-1-n] = 1'b1;
    return v;
  endfunction

  localparam logic [DW-1:0] SRST_MASK   = lbit(7);
  localparam logic [DW-1:0] LE_REQ_MASK = lbit(6);
  localparam logic [DW-1:0] CTRL_MASK   = lbit(0) | lbit(1) | lbit(2) | lbit(3);
  localparam logic [DW-1:0] MAP_MASK    = lbit(7);
  localparam logic [DW-1:0] MAP_RESET   = MAP_MASK;
  localparam logic [DW-1:0] RD_FILL     = '1;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
  import sysio_pkg::*;
(
  input  logic [AW-1:0]    addr,
  input  logic             rd,
  input  logic             wr,
  output logic [NPORT-1:0] rd_sel,
  output logic [NPORT-1:0] wr_sel
);

  logic [NPORT-1:0] hit;

  for (genvar i = 0; i < NPORT; i++) begin : g_cmp
    assign hit[i] = (addr == PORT_TABLE[i*AW +: AW]);
  end

  always_comb begin
    rd_sel = hit & CAN_READ  & {NPORT{rd}};
    wr_sel = hit & CAN_WRITE & {NPORT{wr}};
  end

endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
  import sysio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] wr_sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    srst_q,
  output logic [DW-1:0]    ctrl_q,
  output logic [DW-1:0]    map_q,
  output logic             le_halt_q
);

  logic [DW-1:0] srst_d, ctrl_d, map_d;
  logic          le_halt_d;
  logic          reg_en;

  assign reg_en = wr_sel[PI_SRST] | wr_sel[PI_CTRL] | wr_sel[PI_MAP];

  always_comb begin
    srst_d    = srst_q;
    ctrl_d    = ctrl_q;
    map_d     = map_q;
    le_halt_d = le_halt_q;
    if (wr_sel[PI_SRST]) begin
      srst_d = wdata & SRST_MASK;
      if ((wdata & LE_REQ_MASK) != '0) begin
        le_halt_d = 1'b1;
      end
    end
    if (wr_sel[PI_CTRL]) begin
      ctrl_d = wdata & CTRL_MASK;
    end
    if (wr_sel[PI_MAP]) begin
      map_d = wdata & MAP_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q    <= '0;
      ctrl_q    <= '0;
      map_q     <= MAP_RESET;
      le_halt_q <= 1'b0;
    end else if (reg_en) begin
      srst_q    <= srst_d;
      ctrl_q    <= ctrl_d;
      map_q     <= map_d;
      le_halt_q <= le_halt_d;
    end
  end

endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux
  import sysio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [NPORT-1:0] rd_sel,
  input  logic [DW-1:0]    srst_q,
  input  logic [DW-1:0]    ctrl_q,
  input  logic [DW-1:0]    map_q,
  input  logic [DW-1:0]    strap_equip,
  input  logic [DW-1:0]    strap_board,
  output logic [DW-1:0]    rdata_q
);

  logic [DW-1:0] src [NPORT];
  logic [DW-1:0] rdata_d;

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      src[i] = RD_FILL;
    end
    src[PI_SRST]  = srst_q;
    src[PI_EQUIP] = strap_equip;
    src[PI_KEY]   = '0;
    src[PI_CTRL]  = ctrl_q;
    src[PI_MAP]   = map_q;
    src[PI_BOARD] = strap_board;
  end

  always_comb begin
    rdata_d = RD_FILL;
    for (int i = 0; i < NPORT; i++) begin
      if (rd_sel[i]) begin
        rdata_d = src[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

endmodule

// File: rtl/sysio_parity_win.sv
module sysio_parity_win
  import sysio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              mem_word,
  output logic [MEM_DW-1:0] mem_rdata,
  output logic              mem_ack,
  output logic              mem_err
);

  localparam logic [MEM_AW-1:0] WIN_LAST = WIN_BASE + MEM_AW'(WIN_BYTES - 1);

  logic in_win;
  logic ack_d, err_d;

  assign in_win    = (mem_addr >= WIN_BASE) && (mem_addr <= WIN_LAST);
  assign mem_rdata = '0;

  always_comb begin
    ack_d = in_win && mem_rd && !mem_wr && mem_word;
    err_d = in_win && (mem_wr || (mem_rd && !mem_word));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else begin
      mem_ack <= ack_d;
      mem_err <= err_d;
    end
  end

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DW-1:0]     io_wdata,
  output logic [DW-1:0]     io_rdata,
  input  logic [DW-1:0]     strap_equip,
  input  logic [DW-1:0]     strap_board,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              mem_word,
  output logic [MEM_DW-1:0] mem_rdata,
  output logic              mem_ack,
  output logic              mem_err,
  output logic              soft_rst_o,
  output logic              map_noncontig_o,
  output logic              le_halt_o
);

  logic [NPORT-1:0] rd_sel, wr_sel;
  logic [DW-1:0]    srst_q, ctrl_q, map_q;
  logic             le_halt_q;

  sysio_decode u_dec (
    .addr   (io_addr),
    .rd     (io_rd),
    .wr     (io_wr),
    .rd_sel (rd_sel),
    .wr_sel (wr_sel)
  );

  sysio_ctrl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (wr_sel),
    .wdata     (io_wdata),
    .srst_q    (srst_q),
    .ctrl_q    (ctrl_q),
    .map_q     (map_q),
    .le_halt_q (le_halt_q)
  );

  sysio_rdmux u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (io_rd),
    .rd_sel      (rd_sel),
    .srst_q      (srst_q),
    .ctrl_q      (ctrl_q),
    .map_q       (map_q),
    .strap_equip (strap_equip),
    .strap_board (strap_board),
    .rdata_q     (io_rdata)
  );

  sysio_parity_win u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_word  (mem_word),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err)
  );

  assign soft_rst_o      = (srst_q & SRST_MASK) != '0;
  assign map_noncontig_o = (map_q & MAP_MASK) != '0;
  assign le_halt_o       = le_halt_q;

endmodule

// File: rtl/sysio_regs_chk.sv
module sysio_regs_chk
  import sysio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [DW-1:0]     io_wdata,
  input logic [DW-1:0]     io_rdata,
  input logic [DW-1:0]     strap_equip,
  input logic [DW-1:0]     strap_board,
  input logic [MEM_DW-1:0] mem_rdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              soft_rst_o,
  input logic              map_noncontig_o,
  input logic              le_halt_o
);

  logic wr_srst, wr_map, rd_equip, rd_board, rd_key, rd_lamp;
  assign wr_srst  = io_wr && (io_addr == ADDR_SRST);
  assign wr_map   = io_wr && (io_addr == ADDR_MAP);
  assign rd_equip = io_rd && (io_addr == ADDR_EQUIP);
  assign rd_board = io_rd && (io_addr == ADDR_BOARD);
  assign rd_key   = io_rd && (io_addr == ADDR_KEY);
  assign rd_lamp  = io_rd && (io_addr == ADDR_LAMP);

  assert_srst_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_srst |=> soft_rst_o == $past(io_wdata[0]));

  assert_le_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_srst && io_wdata[1]) |=> le_halt_o);

  assert_le_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    le_halt_o |=> le_halt_o);

  assert_map_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_map |=> map_noncontig_o == $past(io_wdata[0]));

  assert_map_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_map |=> $stable(map_noncontig_o));

  assert_equip_strap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_equip |=> io_rdata == $past(strap_equip));

  assert_board_strap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_board |=> io_rdata == $past(strap_board));

  assert_keylock_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_key |=> io_rdata == '0);

  assert_wo_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lamp |=> io_rdata == RD_FILL);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  assert_win_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ack && mem_err));

  assert_win_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> mem_rdata == '0);

endmodule

bind sysio_regs sysio_regs_chk u_chk (.*);

// File: tb/sim_sysio_regs.sv
module sim_sysio_regs;
  import sysio_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [AW-1:0]     io_addr;
  logic              io_rd, io_wr;
  logic [DW-1:0]     io_wdata, io_rdata;
  logic [DW-1:0]     strap_equip, strap_board;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_rd, mem_wr, mem_word;
  logic [MEM_DW-1:0] mem_rdata;
  logic              mem_ack, mem_err;
  logic              soft_rst_o, map_noncontig_o, le_halt_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // bench model of stored state
  logic [7:0] m_srst, m_ctrl, m_map;
  logic       m_le;

  always #10 clk = ~clk;

  sysio_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_srst = 8'h00; m_ctrl = 8'h00; m_map = 8'h01; m_le = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic io_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == 12'h092) begin
      m_srst = d & 8'h01;
      if (d[1]) m_le = 1'b1;
    end else if (a == 12'h81C) begin
      m_ctrl = d & 8'hF0;
    end else if (a == 12'h850) begin
      m_map = d & 8'h01;
    end
  endtask

  task automatic io_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  function automatic logic [7:0] exp_read(input logic [11:0] a);
    case (a)
      12'h092: return m_srst;
      12'h80C: return strap_equip;
      12'h818: return 8'h00;
      12'h81C: return m_ctrl;
      12'h850: return m_map;
      12'h852: return strap_board;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check_outputs(input string req);
    chk(req, {31'd0, soft_rst_o}, {31'd0, m_srst[0]});
    chk(req, {31'd0, map_noncontig_o}, {31'd0, m_map[0]});
    chk(req, {31'd0, le_halt_o}, {31'd0, m_le});
  endtask

  task automatic mem_access(input logic [31:0] a, input logic r, input logic w, input logic word);
    logic inw;
    @(negedge clk);
    mem_addr = a; mem_rd = r; mem_wr = w; mem_word = word;
    @(negedge clk);
    mem_rd = 1'b0; mem_wr = 1'b0;
    inw = (a >= 32'hBFFF_EFF0) && (a <= 32'hBFFF_EFF3);
    chk("R9 ack", {31'd0, mem_ack}, {31'd0, inw && r && !w && word});
    chk("R9 err", {31'd0, mem_err}, {31'd0, inw && (w || (r && !word))});
    chk("R9 rdata", mem_rdata, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; io_addr = '0; io_rd = 0; io_wr = 0; io_wdata = '0;
    strap_equip = 8'hA5; strap_board = 8'h3C;
    mem_addr = '0; mem_rd = 0; mem_wr = 0; mem_word = 0;
    m_srst = 0; m_ctrl = 0; m_map = 8'h01; m_le = 0;
    repeat (2) @(negedge clk);
    // R1: outputs while in reset
    chk("R1 map in reset", {31'd0, map_noncontig_o}, 32'd1);
    chk("R1 srst in reset", {31'd0, soft_rst_o}, 32'd0);
    do_reset();
    check_outputs("R1 after reset");
    io_read(12'h092, rd); chk("R1 read 092", {24'd0, rd}, 32'h00);
    io_read(12'h81C, rd); chk("R1 read 81C", {24'd0, rd}, 32'h00);
    io_read(12'h850, rd); chk("R1 read 850", {24'd0, rd}, 32'h01);

    // R2/R4/R5: every data value on the writable ports; R3 bit 1 only on 092
    for (int v = 0; v < 256; v++) begin
      if (v[1] == 1'b0) begin
        io_write(12'h092, 8'(v));
        check_outputs("R2 write 092");
        io_read(12'h092, rd); chk("R2 read 092", {24'd0, rd}, {24'd0, m_srst});
      end
      io_write(12'h81C, 8'(v));
      io_read(12'h81C, rd); chk("R4 read 81C", {24'd0, rd}, {24'd0, m_ctrl});
      io_write(12'h850, 8'(v));
      check_outputs("R5 write 850");
      io_read(12'h850, rd); chk("R5 read 850", {24'd0, rd}, {24'd0, m_map});
    end

    // R8: output changes only at the capturing edge
    @(negedge clk);
    io_addr = 12'h092; io_wdata = 8'h01; io_wr = 1'b1;
    #1 chk("R8 before edge", {31'd0, soft_rst_o}, {31'd0, m_srst[0]});
    @(negedge clk); io_wr = 1'b0; m_srst = 8'h01;
    chk("R8 after edge", {31'd0, soft_rst_o}, 32'd1);
    // R8: read data holds without a strobe
    io_read(12'h852, rd);
    repeat (3) @(negedge clk);
    chk("R8 hold", {24'd0, io_rdata}, {24'd0, strap_board});

    // R3: little-endian request raises a sticky halt, bit not stored
    io_write(12'h092, 8'h03);
    check_outputs("R3 raise");
    io_read(12'h092, rd); chk("R3 not stored", {24'd0, rd}, 32'h01);
    io_write(12'h092, 8'h00);
    chk("R3 sticky", {31'd0, le_halt_o}, 32'd1);
    do_reset();
    chk("R3 cleared by reset", {31'd0, le_halt_o}, 32'd0);
    chk("R1 map restored", {31'd0, map_noncontig_o}, 32'd1);

    // R6: strap patterns
    for (int s = 0; s < 8; s++) begin
      strap_equip = 8'(8'h01 << s);
      strap_board = ~8'(8'h01 << s);
      io_read(12'h80C, rd); chk("R6 equip", {24'd0, rd}, {24'd0, strap_equip});
      io_read(12'h852, rd); chk("R6 board", {24'd0, rd}, {24'd0, strap_board});
      io_read(12'h818, rd); chk("R6 keylock", {24'd0, rd}, 32'h00);
    end

    // R7: set known state, then write every other address and sweep reads
    io_write(12'h092, 8'h01);
    io_write(12'h81C, 8'hA0);
    io_write(12'h850, 8'h00);
    for (int a = 0; a < 4096; a++) begin
      if (a != 12'h092 && a != 12'h81C && a != 12'h850) begin
        io_write(12'(a), 8'(a) ^ 8'hFF);
      end
    end
    check_outputs("R7 writes ignored");
    for (int a = 0; a < 4096; a++) begin
      io_read(12'(a), rd);
      chk("R7 address map", {24'd0, rd}, {24'd0, exp_read(12'(a))});
    end

    // R9: window access sweep
    for (int off = -4; off < 8; off++) begin
      mem_access(32'hBFFF_EFF0 + 32'(off), 1'b1, 1'b0, 1'b1);
      mem_access(32'hBFFF_EFF0 + 32'(off), 1'b1, 1'b0, 1'b0);
      mem_access(32'hBFFF_EFF0 + 32'(off), 1'b0, 1'b1, 1'b1);
    end
    mem_access(32'h0000_0000, 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule